// File: doc/BRIEF.md
# Segmented User Address Relocation Unit

This block sits between a processor's address path and a word-addressed main memory. It translates 14-bit logical word addresses into 15-bit physical addresses, so that up to 32K words can be reached. The logical space is cut into eight 2K-word segments. Each segment has its own relocation entry, which holds a 4-bit physical frame number, an enable flag and a read-only flag. The translation is purely combinational, so the physical address, the fault flags and the memory strobe are valid in the same cycle as the request.

The current processor mode controls whether an access is translated. Accesses in user mode are always translated. In monitor mode, only an instruction whose sign bit is set is translated; every other monitor access passes through untouched. In normal mode every address passes through untouched.

Monitor code loads the relocation entries through a write port, one entry per cycle. An access to a disabled segment, or a write to a read-only segment, raises a fault flag and holds back the memory strobe, so memory is not changed.

Top module: `seg_reloc_unit`

## Requirements
- R1: For a translated access, the segment index is `laddr_i[13:11]` and the offset is `laddr_i[10:0]`. The output is `paddr_o = {frame, offset}`, where `frame` is the 4-bit frame number stored for that segment.
- R2: Mode code 2'b10 (user) translates every access, and so does the unused code 2'b11.
- R3: In mode code 2'b01 (monitor), an access is translated when `sign_i` is 1. When `sign_i` is 0 the access passes through with `paddr_o = {1'b0, laddr_i}`.
- R4: In mode code 2'b00 (normal), every access passes through with `paddr_o = {1'b0, laddr_i}` and no fault is raised.
- R5: `bypass_o` is 1 exactly when an access is not translated.
- R6: A translated request (`req_i`=1) to a segment whose enable flag is 0 sets `flt_disabled_o` and holds `mem_stb_o` at 0.
- R7: A translated write request (`wr_i`=1) to an enabled segment whose read-only flag is 1 sets `flt_ro_o` and holds `mem_stb_o` at 0. A translated read of that segment completes normally.
- R8: A disabled segment reports only `flt_disabled_o`, never `flt_ro_o`.
- R9: A load (`ld_en_i`=1) writes the segment selected by `ld_sel_i` with `ld_frame_i`, `ld_enable_i` and `ld_ro_i` at the clock edge, and only while the mode is 2'b01. In any other mode the load is ignored. Accesses in the cycle of the load still see the old entry.
- R10: When `req_i` is 0, `mem_stb_o`, `flt_disabled_o` and `flt_ro_o` are all 0. When `req_i` is 1 and there is no fault, `mem_stb_o` is 1.
- R11: After reset every segment is disabled, with frame 0 and the read-only flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Processor mode: 00 normal, 01 monitor, 10 user, 11 treated as user |
| sign_i | input | 1 | Sign bit of the current instruction |
| req_i | input | 1 | Memory access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| laddr_i | input | 14 | Logical word address |
| ld_en_i | input | 1 | Load strobe for a relocation entry |
| ld_sel_i | input | 3 | Segment whose entry is loaded |
| ld_frame_i | input | 4 | Frame number to load |
| ld_enable_i | input | 1 | Enable flag to load |
| ld_ro_i | input | 1 | Read-only flag to load |
| paddr_o | output | 15 | Physical word address |
| bypass_o | output | 1 | Address passed through untranslated |
| mem_stb_o | output | 1 | Physical access strobe |
| flt_disabled_o | output | 1 | Access hit a disabled segment |
| flt_ro_o | output | 1 | Write hit a read-only segment |

## Verification
The bench builds the block with its default parameters: 14 logical bits, 3 segment bits and 15 physical bits. With these values the sweep covers all eight segments and all sixteen frames, including frame 15 together with the top offset of segment 7, which is the highest physical word. Random stimulus mixes all four mode codes, both sign values, reads and writes, and loads that are issued in the wrong mode. A reference model in the bench holds its own copy of the entries and predicts every output. Directed cases cover the reset state, the same-cycle load hazard and the case where both the enable and read-only flags are set.

// File: rtl/seg_reloc_pkg.sv
// Package for the segmented relocation unit.
// Holds the processor mode encoding that the decoder and the bench share.
package seg_reloc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_MONITOR = 2'b01,
        MODE_USER    = 2'b10,
        MODE_SPARE   = 2'b11
    } cpu_mode_e;
endpackage

// File: rtl/seg_reloc_mode_dec.sv
// Mode decoder.
// Decides whether the current access is translated, and whether a load of
// a relocation entry is allowed this cycle.
// Assumes the spare mode code behaves like user mode, which keeps
// protection in force.
module seg_reloc_mode_dec
    import seg_reloc_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    output logic       map_o,
    output logic       ld_ok_o
);
    // Purpose: pick translation and load permission from the mode.
    always_comb begin
        map_o   = 1'b0;
        ld_ok_o = 1'b0;
        unique case (cpu_mode_e'(mode_i))
            MODE_NORMAL:  map_o = 1'b0;
            MODE_MONITOR: begin
                map_o   = sign_i;
                ld_ok_o = 1'b1;
            end
            MODE_USER:    map_o = 1'b1;
            MODE_SPARE:   map_o = 1'b1;
            default:      map_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/seg_reloc_regfile.sv
// Relocation entry store.
// Holds one entry per segment: frame number, enable flag and read-only flag.
// Assumes the load gate (mode check) is applied by the caller through
// wr_ok_i. Reset is synchronous and active low; it clears every entry.
module seg_reloc_regfile #(
    parameter int NSEG       = 8,
    parameter int SEL_BITS   = 3,
    parameter int FRAME_BITS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_ok_i,
    input  logic [SEL_BITS-1:0]              wr_sel_i,
    input  logic [FRAME_BITS-1:0]            wr_frame_i,
    input  logic                             wr_en_i,
    input  logic                             wr_ro_i,
    output logic [NSEG-1:0][FRAME_BITS-1:0]  frame_o,
    output logic [NSEG-1:0]                  en_o,
    output logic [NSEG-1:0]                  ro_o
);
    for (genvar s = 0; s < NSEG; s++) begin : g_entry
        logic hit;
        assign hit = wr_ok_i && (wr_sel_i == SEL_BITS'(s));

        // Purpose: hold or reload the entry of segment s.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_o[s] <= '0;
                en_o[s]    <= 1'b0;
                ro_o[s]    <= 1'b0;
            end else if (hit) begin
                frame_o[s] <= wr_frame_i;
                en_o[s]    <= wr_en_i;
                ro_o[s]    <= wr_ro_i;
            end
        end
    end
endmodule

// File: rtl/seg_reloc_xlate.sv
// Combinational translator.
// Selects the entry for the segment field, builds the physical address,
// raises faults and gates the memory strobe.
// Assumes PHYS_AW >= LOG_AW, so an untranslated address fits by zero
// extension.
module seg_reloc_xlate #(
    parameter int LOG_AW     = 14,
    parameter int SEL_BITS   = 3,
    parameter int PHYS_AW    = 15,
    parameter int NSEG       = 8,
    parameter int OFF_BITS   = 11,
    parameter int FRAME_BITS = 4
) (
    input  logic                            map_i,
    input  logic                            req_i,
    input  logic                            wr_i,
    input  logic [LOG_AW-1:0]               laddr_i,
    input  logic [NSEG-1:0][FRAME_BITS-1:0] frame_i,
    input  logic [NSEG-1:0]                 en_i,
    input  logic [NSEG-1:0]                 ro_i,
    output logic [PHYS_AW-1:0]              paddr_o,
    output logic                            bypass_o,
    output logic                            stb_o,
    output logic                            f_dis_o,
    output logic                            f_ro_o
);
    logic [SEL_BITS-1:0] sel;
    logic [OFF_BITS-1:0] off;

    assign sel = laddr_i[LOG_AW-1 -: SEL_BITS];
    assign off = laddr_i[OFF_BITS-1:0];

    // Purpose: form the address and decide the fault and strobe outputs.
    always_comb begin
        bypass_o = !map_i;
        f_dis_o  = 1'b0;
        f_ro_o   = 1'b0;
        if (map_i) begin
            paddr_o = {frame_i[sel], off};
            f_dis_o = req_i && !en_i[sel];
            f_ro_o  = req_i && wr_i && en_i[sel] && ro_i[sel];
        end else begin
            paddr_o = PHYS_AW'(laddr_i);
        end
        stb_o = req_i && !f_dis_o && !f_ro_o;
    end
endmodule

// File: rtl/seg_reloc_unit.sv
// Segmented user address relocation unit (top).
// Eight relocation entries map the logical segments onto physical frames.
// The mode decoder, the entry store and the translator are wired here.
// Assumes loads and accesses may occur in the same cycle; the access then
// sees the entry as it was before the load.
module seg_reloc_unit #(
    parameter int LOG_AW   = 14,
    parameter int SEL_BITS = 3,
    parameter int PHYS_AW  = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  sign_i,
    input  logic                  req_i,
    input  logic                  wr_i,
    input  logic [LOG_AW-1:0]     laddr_i,
    input  logic                  ld_en_i,
    input  logic [SEL_BITS-1:0]   ld_sel_i,
    input  logic [PHYS_AW-LOG_AW+SEL_BITS-1:0] ld_frame_i,
    input  logic                  ld_enable_i,
    input  logic                  ld_ro_i,
    output logic [PHYS_AW-1:0]    paddr_o,
    output logic                  bypass_o,
    output logic                  mem_stb_o,
    output logic                  flt_disabled_o,
    output logic                  flt_ro_o
);
    localparam int NSEG       = 1 << SEL_BITS;
    localparam int OFF_BITS   = LOG_AW - SEL_BITS;
    localparam int FRAME_BITS = PHYS_AW - OFF_BITS;

    logic                            map_w;
    logic                            ld_ok_w;
    logic [NSEG-1:0][FRAME_BITS-1:0] frame_w;
    logic [NSEG-1:0]                 en_w;
    logic [NSEG-1:0]                 ro_w;

    seg_reloc_mode_dec u_dec (
        .mode_i  (mode_i),
        .sign_i  (sign_i),
        .map_o   (map_w),
        .ld_ok_o (ld_ok_w)
    );

    seg_reloc_regfile #(
        .NSEG(NSEG), .SEL_BITS(SEL_BITS), .FRAME_BITS(FRAME_BITS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok_i    (ld_en_i && ld_ok_w),
        .wr_sel_i   (ld_sel_i),
        .wr_frame_i (ld_frame_i),
        .wr_en_i    (ld_enable_i),
        .wr_ro_i    (ld_ro_i),
        .frame_o    (frame_w),
        .en_o       (en_w),
        .ro_o       (ro_w)
    );

    seg_reloc_xlate #(
        .LOG_AW(LOG_AW), .SEL_BITS(SEL_BITS), .PHYS_AW(PHYS_AW),
        .NSEG(NSEG), .OFF_BITS(OFF_BITS), .FRAME_BITS(FRAME_BITS)
    ) u_xl (
        .map_i    (map_w),
        .req_i    (req_i),
        .wr_i     (wr_i),
        .laddr_i  (laddr_i),
        .frame_i  (frame_w),
        .en_i     (en_w),
        .ro_i     (ro_w),
        .paddr_o  (paddr_o),
        .bypass_o (bypass_o),
        .stb_o    (mem_stb_o),
        .f_dis_o  (flt_disabled_o),
        .f_ro_o   (flt_ro_o)
    );
endmodule

// File: rtl/seg_reloc_checker.sv
// Property checker for seg_reloc_unit, bound to every instance of the top.
// It relates the top's ports to one another over time.
module seg_reloc_checker #(
    parameter int LOG_AW   = 14,
    parameter int SEL_BITS = 3,
    parameter int PHYS_AW  = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_i,
    input logic                sign_i,
    input logic                req_i,
    input logic                wr_i,
    input logic [LOG_AW-1:0]   laddr_i,
    input logic [PHYS_AW-1:0]  paddr_o,
    input logic                bypass_o,
    input logic                mem_stb_o,
    input logic                flt_disabled_o,
    input logic                flt_ro_o
);
    localparam int OFF_BITS = LOG_AW - SEL_BITS;

    a_r4_normal_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> (bypass_o && paddr_o == PHYS_AW'(laddr_i)
                               && !flt_disabled_o && !flt_ro_o));

    a_r2_user_translates: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1]) |-> !bypass_o);

    a_r3_monitor_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> (bypass_o == !sign_i));

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_o) |-> (paddr_o[OFF_BITS-1:0] == laddr_i[OFF_BITS-1:0]));

    a_r10_no_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i) |-> (!mem_stb_o && !flt_disabled_o && !flt_ro_o));

    a_r6_fault_blocks_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_disabled_o || flt_ro_o) |-> !mem_stb_o);

    a_r7_ro_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        flt_ro_o |-> (wr_i && req_i && !bypass_o));

    a_r8_faults_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_ro_o && flt_disabled_o));
endmodule

bind seg_reloc_unit seg_reloc_checker #(
    .LOG_AW(LOG_AW), .SEL_BITS(SEL_BITS), .PHYS_AW(PHYS_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sign_i(sign_i),
    .req_i(req_i), .wr_i(wr_i), .laddr_i(laddr_i), .paddr_o(paddr_o),
    .bypass_o(bypass_o), .mem_stb_o(mem_stb_o),
    .flt_disabled_o(flt_disabled_o), .flt_ro_o(flt_ro_o)
);

// File: tb/seg_reloc_unit_test.sv
// Bench for seg_reloc_unit: directed corner cases followed by seeded random
// stimulus, each checked against a reference model of the entries.
module seg_reloc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        sign_i = 1'b0, req_i = 1'b0, wr_i = 1'b0;
    logic [13:0] laddr_i = '0;
    logic        ld_en_i = 1'b0;
    logic [2:0]  ld_sel_i = '0;
    logic [3:0]  ld_frame_i = '0;
    logic        ld_enable_i = 1'b0, ld_ro_i = 1'b0;
    logic [14:0] paddr_o;
    logic        bypass_o, mem_stb_o, flt_disabled_o, flt_ro_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference copy of the relocation entries.
    logic [3:0] m_frame [8];
    logic       m_en    [8];
    logic       m_ro    [8];

    always #2.5 clk = ~clk;

    seg_reloc_unit uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sign_i(sign_i),
        .req_i(req_i), .wr_i(wr_i), .laddr_i(laddr_i), .ld_en_i(ld_en_i),
        .ld_sel_i(ld_sel_i), .ld_frame_i(ld_frame_i),
        .ld_enable_i(ld_enable_i), .ld_ro_i(ld_ro_i), .paddr_o(paddr_o),
        .bypass_o(bypass_o), .mem_stb_o(mem_stb_o),
        .flt_disabled_o(flt_disabled_o), .flt_ro_o(flt_ro_o)
    );

    function automatic bit exp_map(input logic [1:0] m, input logic s);
        return (m == 2'b10) || (m == 2'b11) || (m == 2'b01 && s);
    endfunction

    // Expected outputs, packed as {paddr, bypass, stb, fdis, fro}.
    function automatic logic [18:0] expect_out();
        logic [14:0] pa;
        logic        mp, fd, fr, st;
        logic [2:0]  sg;
        sg = laddr_i[13:11];
        mp = exp_map(mode_i, sign_i);
        pa = mp ? {m_frame[sg], laddr_i[10:0]} : {1'b0, laddr_i};
        fd = mp && req_i && !m_en[sg];
        fr = mp && req_i && wr_i && m_en[sg] && m_ro[sg];
        st = req_i && !fd && !fr;
        return {pa, !mp, st, fd, fr};
    endfunction

    task automatic check(input string tag);
        logic [18:0] got, exp;
        got = {paddr_o, bypass_o, mem_stb_o, flt_disabled_o, flt_ro_o};
        exp = expect_out();
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got paddr=%h byp=%b stb=%b fd=%b fr=%b, expected paddr=%h byp=%b stb=%b fd=%b fr=%b",
                     tag, got[18:4], got[3], got[2], got[1], got[0],
                     exp[18:4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    // One cycle: drive at the falling edge, check, then let the edge commit.
    task automatic step(input logic [1:0] m, input logic s, input logic rq,
                        input logic w, input logic [13:0] a, input logic le,
                        input logic [2:0] ls, input logic [3:0] lf,
                        input logic len, input logic lro, input string tag);
        @(negedge clk);
        mode_i = m; sign_i = s; req_i = rq; wr_i = w; laddr_i = a;
        ld_en_i = le; ld_sel_i = ls; ld_frame_i = lf;
        ld_enable_i = len; ld_ro_i = lro;
        #1;
        check(tag);
        @(posedge clk);
        if (le && m == 2'b01) begin
            m_frame[ls] = lf; m_en[ls] = len; m_ro[ls] = lro;
        end
    endtask

    task automatic load(input logic [2:0] sg, input logic [3:0] fr,
                        input logic en, input logic ro);
        step(2'b01, 1'b0, 1'b0, 1'b0, 14'h0, 1'b1, sg, fr, en, ro, "R9 load");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5e6d;
        void'($urandom(seed));
        for (int i = 0; i < 8; i++) begin
            m_frame[i] = '0; m_en[i] = 1'b0; m_ro[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: every segment disabled after reset, frame 0.
        for (int sg = 0; sg < 8; sg++)
            step(2'b10, 1'b0, 1'b1, 1'b0, {3'(sg), 11'h155}, 1'b0, 0, 0, 0, 0,
                 "R11 reset disabled");

        // R4: normal mode passes through even with sign set and a request.
        step(2'b00, 1'b1, 1'b1, 1'b1, 14'h3abc, 1'b0, 0, 0, 0, 0, "R4 normal");

        // R9: a load in user mode is ignored.
        step(2'b10, 1'b0, 1'b0, 1'b0, 14'h0, 1'b1, 3'd2, 4'h9, 1'b1, 1'b0,
             "R9 user load");
        step(2'b10, 1'b0, 1'b1, 1'b0, {3'd2, 11'h010}, 1'b0, 0, 0, 0, 0,
             "R9 user load ignored");
        // R9: a load in normal mode is ignored.
        step(2'b00, 1'b0, 1'b0, 1'b0, 14'h0, 1'b1, 3'd2, 4'h9, 1'b1, 1'b0,
             "R9 normal load");
        step(2'b11, 1'b0, 1'b1, 1'b0, {3'd2, 11'h010}, 1'b0, 0, 0, 0, 0,
             "R9 normal load ignored");

        // R9: same-cycle access sees the old entry, the next cycle the new one.
        step(2'b01, 1'b1, 1'b1, 1'b0, {3'd5, 11'h7ff}, 1'b1, 3'd5, 4'hc,
             1'b1, 1'b0, "R9 same cycle old");
        step(2'b01, 1'b1, 1'b1, 1'b0, {3'd5, 11'h7ff}, 1'b0, 0, 0, 0, 0,
             "R9 next cycle new");

        // R3: monitor without sign passes through.
        step(2'b01, 1'b0, 1'b1, 1'b1, {3'd5, 11'h123}, 1'b0, 0, 0, 0, 0,
             "R3 monitor no sign");

        // R1: segment 7 in frame 15, highest physical word.
        load(3'd7, 4'hf, 1'b1, 1'b0);
        step(2'b10, 1'b0, 1'b1, 1'b1, 14'h3fff, 1'b0, 0, 0, 0, 0, "R1 top word");

        // R7: read-only segment: write faults, read works.
        load(3'd3, 4'h6, 1'b1, 1'b1);
        step(2'b10, 1'b0, 1'b1, 1'b1, {3'd3, 11'h044}, 1'b0, 0, 0, 0, 0,
             "R7 ro write");
        step(2'b10, 1'b0, 1'b1, 1'b0, {3'd3, 11'h044}, 1'b0, 0, 0, 0, 0,
             "R7 ro read");

        // R8: disabled and read-only together: only the disabled fault.
        load(3'd4, 4'h1, 1'b0, 1'b1);
        step(2'b10, 1'b0, 1'b1, 1'b1, {3'd4, 11'h001}, 1'b0, 0, 0, 0, 0,
             "R8 dis and ro");
        // R10: no request, no strobe and no fault on the same segment.
        step(2'b10, 1'b0, 1'b0, 1'b1, {3'd4, 11'h001}, 1'b0, 0, 0, 0, 0,
             "R10 idle");
        // R6: disabled segment faults.
        step(2'b11, 1'b0, 1'b1, 1'b0, {3'd0, 11'h2aa}, 1'b0, 0, 0, 0, 0,
             "R6 disabled");

        // Random phase: R1 R2 R3 R5 R6 R7 R9 R10 mixed.
        for (int k = 0; k < 3000; k++) begin
            logic [1:0]  rm;
            logic        rs, rq, rw, rl;
            logic [13:0] ra;
            logic [2:0]  rsel;
            logic [3:0]  rf;
            logic [1:0]  rflags;
            rm = 2'($urandom_range(0, 3));
            rs = 1'($urandom_range(0, 1));
            rq = ($urandom_range(0, 9) != 0);
            rw = 1'($urandom_range(0, 1));
            ra = 14'($urandom);
            rl = ($urandom_range(0, 3) == 0);
            rsel = 3'($urandom);
            rf = 4'($urandom);
            rflags = 2'($urandom);
            step(rm, rs, rq, rw, ra, rl, rsel, rf, ~|rflags ? 1'b0 : 1'b1,
                 rflags[1], "R5 random mix");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule